// File: doc/BRIEF.md
# Clock reference switchover controller

This block decides which of three clock sources drives a PLL input: a primary reference A, a secondary reference B, or a crystal kept for holdover. It runs on a sampling clock that never stops, such as the PLL feedback clock. It takes one presence flag per source, a 2-bit policy mode, an external select pin and a select bit from a control register. Its outputs are a 2-bit mux select and two status flags. One status flag reports holdover. The other reports that no usable source is selected.

Two modes switch automatically. In the revertive mode, reference A is always preferred. In the nonrevertive mode, the block stays on B once it has moved there. In both automatic modes, when both references are missing, the block falls back to the crystal. Two manual modes pick the reference from the pin or from the register bit. The manual modes never fall back to the crystal. Each presence flag is synchronized through two flops before the block uses it. The mode and select inputs are used as they arrive.

Top module: `refsw_ctrl`

## Requirements
- R1: After reset the select output is 2'b11 (none), no_input_o is 1 and holdover_o is 0. The select encoding is 2'b00 = A, 2'b01 = B, 2'b10 = crystal, 2'b11 = none.
- R2: Each presence flag passes through two synchronizing flops. The selection register then updates on the next edge. A change of a presence input therefore reaches the outputs by the third rising edge after the change.
- R3: In mode 2'b00 (revertive), A is selected whenever A is present. B is selected when A is absent and B is present. The select returns to A as soon as A is present again.
- R4: In mode 2'b01 (nonrevertive), the block stays on B while B is present, even if A returns. In every other case it prefers A, then B.
- R5: In modes 2'b00 and 2'b01, when both A and B are absent and the crystal is present, the crystal is selected and holdover_o is 1.
- R6: When none of the usable sources is present, the select is 2'b11 and no_input_o is 1. Selection resumes under the current mode when any of those sources returns.
- R7: In mode 2'b10, the pin chooses the reference (0 = A, 1 = B) and the register bit is ignored. In mode 2'b11, the register bit chooses the reference in the same way and the pin is ignored.
- R8: In modes 2'b10 and 2'b11, an absent chosen reference gives select 2'b11 with no_input_o = 1. The crystal is never selected in these modes, and holdover_o stays 0.
- R9: holdover_o is 1 exactly while the crystal is selected, and holdover_o and no_input_o are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pres_a_i | input | 1 | Reference A present |
| pres_b_i | input | 1 | Reference B present |
| pres_x_i | input | 1 | Crystal present |
| mode_i | input | 2 | Policy: 00 revertive, 01 nonrevertive, 10 pin manual, 11 register manual |
| pin_sel_i | input | 1 | External manual select (1 = B) |
| reg_sel_i | input | 1 | Register manual select (1 = B) |
| src_sel_o | output | 2 | Mux select: 00 A, 01 B, 10 crystal, 11 none |
| holdover_o | output | 1 | Crystal selected by automatic fallback |
| no_input_o | output | 1 | No source selected |

## Verification
On every cycle, the assertions check the following, measured against the synchronized presence flags:
- the revertive preference for A,
- the nonrevertive stickiness on B,
- the rule that the manual modes never select the crystal,
- entry into the none state when all sources are missing,
- the exclusive status flags.

Some behaviours are visible only in the bench's directed scenarios:
- the full sequences through loss and return of each source,
- the three-edge latency from a raw input to the outputs,
- the manual modes ignoring the select they do not use,
- mode changes while on B.

// File: rtl/refsw_pkg.sv
package refsw_pkg;
    localparam int unsigned NUM_SRC = 3;
    localparam int unsigned IDX_A   = 0;
    localparam int unsigned IDX_B   = 1;
    localparam int unsigned IDX_X   = 2;

    typedef enum logic [1:0] {
        SRC_A    = 2'b00,
        SRC_B    = 2'b01,
        SRC_X    = 2'b10,
        SRC_NONE = 2'b11
    } src_e;

    typedef enum logic [1:0] {
        MODE_REVERT = 2'b00,
        MODE_STICKY = 2'b01,
        MODE_PIN    = 2'b10,
        MODE_REG    = 2'b11
    } mode_e;

    typedef struct packed {
        src_e sel;
        logic hold;
        logic none;
    } state_t;
endpackage

// File: rtl/refsw_sync.sv
module refsw_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    localparam int unsigned LAST = STAGES - 1;

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        logic [STAGES-1:0] chain_d;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], async_i[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= chain_d;
        end

        assign sync_o[g] = chain_q[LAST];
    end
endmodule

// File: rtl/refsw_policy.sv
module refsw_policy
    import refsw_pkg::*;
(
    input  logic [NUM_SRC-1:0] flags_i,
    input  logic [1:0]         mode_i,
    input  logic               pin_sel_i,
    input  logic               reg_sel_i,
    input  src_e               cur_i,
    output src_e               next_o
);
    logic a_ok, b_ok, x_ok;
    logic man_b;

    assign a_ok = flags_i[IDX_A];
    assign b_ok = flags_i[IDX_B];
    assign x_ok = flags_i[IDX_X];

    always_comb begin
        man_b  = (mode_i == MODE_PIN) ? pin_sel_i : reg_sel_i;
        next_o = SRC_NONE;
        unique case (mode_i)
            MODE_REVERT: begin
                if      (a_ok) next_o = SRC_A;
                else if (b_ok) next_o = SRC_B;
                else if (x_ok) next_o = SRC_X;
            end
            MODE_STICKY: begin
                if      (cur_i == SRC_B && b_ok) next_o = SRC_B;
                else if (a_ok)                   next_o = SRC_A;
                else if (b_ok)                   next_o = SRC_B;
                else if (x_ok)                   next_o = SRC_X;
            end
            default: begin
                if (man_b) next_o = b_ok ? SRC_B : SRC_NONE;
                else       next_o = a_ok ? SRC_A : SRC_NONE;
            end
        endcase
    end
endmodule

// File: rtl/refsw_ctrl.sv
module refsw_ctrl
    import refsw_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pres_a_i,
    input  logic       pres_b_i,
    input  logic       pres_x_i,
    input  logic [1:0] mode_i,
    input  logic       pin_sel_i,
    input  logic       reg_sel_i,
    output logic [1:0] src_sel_o,
    output logic       holdover_o,
    output logic       no_input_o
);
    logic [NUM_SRC-1:0] flag_raw;
    logic [NUM_SRC-1:0] flag_s;
    src_e               next_sel;
    state_t             st_d, st_q;

    assign flag_raw[IDX_A] = pres_a_i;
    assign flag_raw[IDX_B] = pres_b_i;
    assign flag_raw[IDX_X] = pres_x_i;

    refsw_sync #(
        .WIDTH  (NUM_SRC),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (flag_raw),
        .sync_o  (flag_s)
    );

    refsw_policy u_policy (
        .flags_i   (flag_s),
        .mode_i    (mode_i),
        .pin_sel_i (pin_sel_i),
        .reg_sel_i (reg_sel_i),
        .cur_i     (st_q.sel),
        .next_o    (next_sel)
    );

    always_comb begin
        st_d      = st_q;
        st_d.sel  = next_sel;
        st_d.hold = (next_sel == SRC_X);
        st_d.none = (next_sel == SRC_NONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sel  <= SRC_NONE;
            st_q.hold <= 1'b0;
            st_q.none <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign src_sel_o  = st_q.sel;
    assign holdover_o = st_q.hold;
    assign no_input_o = st_q.none;
endmodule

// File: rtl/refsw_ctrl_sva.sv
module refsw_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] flags,
    input logic [1:0] mode,
    input logic [1:0] sel,
    input logic       hold,
    input logic       none
);
    // R3: revertive mode with A present selects A on the next edge
    a_r3_revert_to_a: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 && flags[0]) |=> (sel == 2'b00));

    // R4: nonrevertive mode keeps B while B is present
    a_r4_sticky_b: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && sel == 2'b01 && flags[1]) |=> (sel == 2'b01));

    // R5: holdover starts only after both references were missing and the crystal was present
    a_r5_hold_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold) |-> $past(!flags[0] && !flags[1] && flags[2]));

    // R6: all sources missing leads to the none state
    a_r6_all_absent: assert property (@(posedge clk) disable iff (!rst_n)
        (flags == 3'b000) |=> (none && sel == 2'b11));

    // R8: manual modes never pick the crystal
    a_r8_manual_no_xtal: assert property (@(posedge clk) disable iff (!rst_n)
        mode[1] |=> (sel != 2'b10 && !hold));

    // R9: status flags are exclusive
    a_r9_status_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(hold && none));
endmodule

bind refsw_ctrl refsw_ctrl_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .flags (flag_s),
    .mode  (mode_i),
    .sel   (src_sel_o),
    .hold  (holdover_o),
    .none  (no_input_o)
);

// File: tb/refsw_ctrl_tb.sv
module refsw_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pa = 1'b0, pb = 1'b0, px = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       pin = 1'b0, rsel = 1'b0;
    logic [1:0] sel;
    logic       hold, none;
    int         total = 0;
    int         bad = 0;
    bit         done = 1'b0;

    localparam logic [1:0] S_A = 2'b00, S_B = 2'b01, S_X = 2'b10, S_N = 2'b11;

    always #2.5 clk = ~clk;

    refsw_ctrl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pres_a_i   (pa),
        .pres_b_i   (pb),
        .pres_x_i   (px),
        .mode_i     (mode),
        .pin_sel_i  (pin),
        .reg_sel_i  (rsel),
        .src_sel_o  (sel),
        .holdover_o (hold),
        .no_input_o (none)
    );

    task automatic check(input string req, input logic [1:0] es, input logic eh, input logic en);
        total++;
        if (sel !== es || hold !== eh || none !== en) begin
            bad++;
            $display("FAIL %s: sel=%b hold=%b none=%b expected sel=%b hold=%b none=%b",
                     req, sel, hold, none, es, eh, en);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_in(input logic a, input logic b, input logic x);
        pa = a; pb = b; px = x;
        settle(4);
    endtask

    task automatic t_reset();
        check("R1 reset", S_N, 1'b0, 1'b1);
    endtask

    task automatic t_latency();
        mode = 2'b00;
        @(negedge clk);
        pa = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R2 not yet after two edges", S_N, 1'b0, 1'b1);
        @(posedge clk);
        @(negedge clk);
        check("R2 visible after three edges", S_A, 1'b0, 1'b0);
    endtask

    task automatic t_revert();
        mode = 2'b00;
        set_in(1, 1, 1); check("R3 A preferred", S_A, 0, 0);
        set_in(0, 1, 1); check("R3 A lost to B", S_B, 0, 0);
        set_in(1, 1, 1); check("R3 returns to A", S_A, 0, 0);
    endtask

    task automatic t_sticky();
        mode = 2'b01;
        set_in(1, 1, 0); check("R4 A first", S_A, 0, 0);
        set_in(0, 1, 0); check("R4 moves to B", S_B, 0, 0);
        set_in(1, 1, 0); check("R4 stays on B", S_B, 0, 0);
        set_in(1, 0, 0); check("R4 B lost to A", S_A, 0, 0);
        set_in(0, 1, 0); check("R4 to B again", S_B, 0, 0);
        mode = 2'b00; settle(1);
        set_in(1, 1, 0); check("R3 mode change reverts", S_A, 0, 0);
    endtask

    task automatic t_holdover();
        mode = 2'b00;
        set_in(0, 0, 1); check("R5 revert holdover", S_X, 1, 0);
        set_in(0, 1, 1); check("R5 leaves to B", S_B, 0, 0);
        mode = 2'b01;
        set_in(0, 0, 1); check("R5 sticky holdover", S_X, 1, 0);
        set_in(1, 1, 1); check("R5 sticky exit prefers A", S_A, 0, 0);
    endtask

    task automatic t_none();
        mode = 2'b00;
        set_in(0, 0, 0); check("R6 all absent", S_N, 0, 1);
        set_in(0, 0, 1); check("R6 crystal returns", S_X, 1, 0);
        set_in(0, 0, 0); check("R6 absent again", S_N, 0, 1);
        set_in(0, 1, 0); check("R6 B returns", S_B, 0, 0);
    endtask

    task automatic t_manual();
        mode = 2'b10; pin = 1'b0; rsel = 1'b1;
        set_in(1, 1, 1); check("R7 pin picks A, reg ignored", S_A, 0, 0);
        pin = 1'b1; settle(1);
        check("R7 pin picks B", S_B, 0, 0);
        set_in(1, 0, 1); check("R8 pin B absent gives none", S_N, 0, 1);
        mode = 2'b11; rsel = 1'b0; pin = 1'b1;
        set_in(1, 1, 1); check("R7 reg picks A, pin ignored", S_A, 0, 0);
        rsel = 1'b1; settle(1);
        check("R7 reg picks B", S_B, 0, 0);
        set_in(0, 0, 1); check("R8 no crystal fallback", S_N, 0, 1);
    endtask

    initial begin
        #20000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: run hung, actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        settle(2);
        check("R1 idle after reset", S_N, 0, 1);
        t_latency();
        t_revert();
        t_sticky();
        t_holdover();
        t_none();
        t_manual();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule